// File: doc/BRIEF.md
# Phase-Accumulator PWM with Deferred Update

This block drives up to four pulse-width modulated outputs, one per channel, each controlled by a single 32-bit configuration word. Each channel adds a programmable step to a phase accumulator on every clock. The upper eight accumulator bits are compared against an 8-bit threshold to produce the output level. The step therefore sets the output frequency, which is the clock rate times the step divided by the accumulator range. The threshold sets the duty inversely: a threshold of 255 gives a constantly low output, and a threshold of 0 gives the widest pulse.

Software writes land in shadow fields. They take effect only after software raises the channel's update bit. The hardware then copies the shadow fields into the active set at the next accumulator wrap and clears the update bit on that same cycle. When the channel is not running, there is no cycle in progress, so the copy happens on the following clock. A channel produces output only once an update has been taken since it was last enabled. While an update is pending, further writes to that channel are refused, and `busy_o` signals the refusal, so a new setting is never half-applied.

Top module: `pwm_acc_top`

## Requirements
- R1: After reset every channel reads back 0x000000FF, `busy_o` is low and all outputs are low.
- R2: Word layout: bit 31 is enable, bit 30 is update, bits [8 +: BASE_W] hold the step and bits [7:0] hold the threshold. All other bits read as 0, and written bits above the step field are discarded.
- R3: While running, the accumulator advances by the active step each clock and wraps modulo 2^BASE_W. For a power-of-two step the output repeats every 2^BASE_W / step cycles.
- R4: While running, the output is high exactly when the upper eight accumulator bits are strictly greater than the active threshold.
- R5: A threshold of 255 holds the output low on every cycle. A threshold of 0 makes it high in 255 of 256 phases.
- R6: Writing new step or threshold values without the update bit changes the read-back value but not the output.
- R7: A set update bit stays set until the next accumulator wrap of a running channel, or until the next clock of a stopped channel. On that cycle the active values are loaded and the bit clears.
- R8: Setting enable while no update has been taken since the last disable leaves the output low. Once an update is taken with enable set, the output runs.
- R9: Clearing enable drives the output low from the next cycle onward. Enabling again without a new update keeps the output low.
- R10: `busy_o` is high while the selected channel has an update pending. A write to that channel during this time is discarded entirely.
- R11: Channels are independent: a write to one channel changes neither the read-back value nor the output of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | SEL_W | Channel selected for write and read-back |
| we_i | input | 1 | Write strobe for the selected channel |
| wdata_i | input | 32 | Configuration word to write |
| rdata_o | output | 32 | Read-back of the selected channel (shadow fields, live update bit, enable) |
| busy_o | output | 1 | Selected channel has an update pending; writes are refused |
| pwm_o | output | N_CH | PWM output per channel |

## Verification
The assertions check on every cycle the rules that hold at each edge: a refused write leaves the shadow fields untouched, and the update bit falls only on a cycle that loaded the active set. They also check that the active threshold changes only at such a load, that an output with threshold 255 is never high, that a channel is armed only by a taken update, and that the output is low the moment enable drops. Duty counts, output period, the wait before an update lands, the need for an update before enabling, and isolation between channels span whole output cycles. The directed scenarios show these by counting high cycles and edge spacing against values computed from the accumulator model.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;
  localparam int REG_W      = 32;
  localparam int EN_BIT     = 31;
  localparam int UPD_BIT    = 30;
  localparam int BASE_LSB   = 8;
  localparam int DIV_W      = 8;
  localparam int MAX_BASE_W = 22;
  localparam logic [DIV_W-1:0] DIV_OFF = '1;
endpackage

// File: rtl/pwm_acc_regs.sv
module pwm_acc_regs
  import pwm_acc_pkg::*;
#(
  parameter int BASE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              apply_i,
  output logic              en_o,
  output logic              upd_o,
  output logic [BASE_W-1:0] base_o,
  output logic [DIV_W-1:0]  div_o
);
  logic              en_q, upd_q;
  logic [BASE_W-1:0] base_q;
  logic [DIV_W-1:0]  div_q;

  // writes are refused while an update is pending; slicing masks the step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      upd_q  <= 1'b0;
      base_q <= '0;
      div_q  <= DIV_OFF;
    end else if (we_i && !upd_q) begin
      en_q   <= wdata_i[EN_BIT];
      upd_q  <= wdata_i[UPD_BIT];
      base_q <= wdata_i[BASE_LSB +: BASE_W];
      div_q  <= wdata_i[DIV_W-1:0];
    end else if (apply_i) begin
      upd_q  <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign upd_o  = upd_q;
  assign base_o = base_q;
  assign div_o  = div_q;

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && upd_q) |=> ($stable(base_q) && $stable(div_q) && $stable(en_q)));

  assert_upd_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(upd_q) |-> $past(apply_i));
endmodule

// File: rtl/pwm_acc_core.sv
module pwm_acc_core
  import pwm_acc_pkg::*;
#(
  parameter int BASE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              upd_i,
  input  logic [BASE_W-1:0] base_sh_i,
  input  logic [DIV_W-1:0]  div_sh_i,
  output logic              apply_o,
  output logic              pwm_o
);
  logic [BASE_W-1:0] acc_q, base_q;
  logic [DIV_W-1:0]  div_q;
  logic              primed_q, en_prev_q;
  logic [BASE_W:0]   sum;
  logic              run, wrap;

  assign run     = en_i && primed_q;
  assign sum     = {1'b0, acc_q} + {1'b0, base_q};
  assign wrap    = sum[BASE_W];
  // a stopped channel has no cycle in flight: take the update at once
  assign apply_o = upd_i && (run ? wrap : 1'b1);
  assign pwm_o   = run && (acc_q[BASE_W-1 -: DIV_W] > div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      base_q    <= '0;
      div_q     <= DIV_OFF;
      primed_q  <= 1'b0;
      en_prev_q <= 1'b0;
    end else begin
      acc_q     <= run ? sum[BASE_W-1:0] : '0;
      en_prev_q <= en_i;
      if (apply_o) begin
        base_q   <= base_sh_i;
        div_q    <= div_sh_i;
        primed_q <= 1'b1;
      end else if (en_prev_q && !en_i) begin
        primed_q <= 1'b0;
      end
    end
  end

  assert_off_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == DIV_OFF) |-> !pwm_o);

  assert_arm_by_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(primed_q) |-> $past(apply_o));

  assert_stop_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |-> !pwm_o);

  assert_div_at_apply_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_q) |-> $past(apply_o));
endmodule

// File: rtl/pwm_acc_top.sv
module pwm_acc_top
  import pwm_acc_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int BASE_W = 16,
  localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             busy_o,
  output logic [N_CH-1:0]  pwm_o
);
  logic [REG_W-1:0] rdata_ch [N_CH];
  logic [N_CH-1:0]  upd_ch;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic              we_c, en_c, apply_c;
    logic [BASE_W-1:0] base_c;
    logic [DIV_W-1:0]  div_c;

    assign we_c = we_i && (sel_i == SEL_W'(c));

    pwm_acc_regs #(.BASE_W(BASE_W)) i_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_c),
      .wdata_i (wdata_i),
      .apply_i (apply_c),
      .en_o    (en_c),
      .upd_o   (upd_ch[c]),
      .base_o  (base_c),
      .div_o   (div_c)
    );

    pwm_acc_core #(.BASE_W(BASE_W)) i_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_c),
      .upd_i     (upd_ch[c]),
      .base_sh_i (base_c),
      .div_sh_i  (div_c),
      .apply_o   (apply_c),
      .pwm_o     (pwm_o[c])
    );

    always_comb begin
      rdata_ch[c]                     = '0;
      rdata_ch[c][EN_BIT]             = en_c;
      rdata_ch[c][UPD_BIT]            = upd_ch[c];
      rdata_ch[c][BASE_LSB +: BASE_W] = base_c;
      rdata_ch[c][DIV_W-1:0]          = div_c;
    end
  end

  always_comb begin
    rdata_o = '0;
    busy_o  = 1'b0;
    for (int c = 0; c < N_CH; c++) begin
      if (sel_i == SEL_W'(c)) begin
        rdata_o = rdata_ch[c];
        busy_o  = upd_ch[c];
      end
    end
  end

  initial begin
    assert_width_ok_R2: assert (BASE_W >= DIV_W && BASE_W <= MAX_BASE_W);
  end
endmodule

// File: tb/test_pwm_acc_top.sv
module test_pwm_acc_top;
  localparam int N_CH = 4;
  localparam int BW   = 16;
  localparam int RNG  = 1 << BW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy;
  logic [N_CH-1:0] pwm;

  int n_cmp = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pwm_acc_top #(.N_CH(N_CH), .BASE_W(BW)) i_pwm_acc_top (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy), .pwm_o(pwm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit upd, input int base, input int dv);
    logic [31:0] w = '0;
    w[31] = en; w[30] = upd; w[8 +: BW] = base[BW-1:0]; w[7:0] = dv[7:0];
    return w;
  endfunction

  // high cycles in one output period, from the accumulator model
  function automatic int exp_high(input int base, input int dv);
    int n = 0;
    for (int k = 0; k < RNG / base; k++)
      if ((((k * base) % RNG) >> (BW - 8)) > dv) n++;
    return n;
  endfunction

  // callers are at a negedge
  task automatic wr(input int ch, input logic [31:0] d);
    sel = ch[1:0]; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [31:0] d);
    sel = ch[1:0]; #1; d = rdata;
  endtask

  task automatic wait_idle(input int ch, output int cyc);
    sel = ch[1:0]; #1; cyc = 0;
    while (busy && cyc < 70000) begin @(negedge clk); cyc++; end
    if (busy) @(negedge clk);
    else begin @(negedge clk); end
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); if (pwm[ch]) hi++; end
  endtask

  task automatic period(input int ch, output int p);
    bit prev = pwm[ch];
    int guard = 0;
    p = 0;
    while (!(!prev && pwm[ch]) && guard < 70000) begin prev = pwm[ch]; @(negedge clk); guard++; end
    prev = pwm[ch];
    @(negedge clk); p = 1;
    while (!(!prev && pwm[ch]) && p < 70000) begin prev = pwm[ch]; @(negedge clk); p++; end
  endtask

  task automatic configure(input int ch, input int base, input int dv);
    int c;
    wr(ch, mk(0, 1, base, dv));
    wait_idle(ch, c);
    wr(ch, mk(1, 0, base, dv));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < N_CH; c++) begin rd(c, d); chk("R1 readback", d, 32'hFF); end
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 outputs", {28'b0, pwm}, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(3, 32'h3F12_3456);
    rd(3, d);
    chk("R2 masked layout", d, 32'h0012_3456);
  endtask

  task automatic t_enable_needs_update();
    int hi, c;
    wr(2, mk(1, 0, 256, 0));
    count_high(2, 300, hi);
    chk("R8 enable without update", hi, 0);
    wr(2, mk(1, 1, 256, 0));
    wait_idle(2, c);
    count_high(2, 256, hi);
    chk("R8 update then run", hi, 255);
    chk("R5 full threshold 0", hi, exp_high(256, 0));
  endtask

  task automatic t_duty();
    int hi, p, c;
    configure(0, 256, 128);
    count_high(0, 256, hi);
    chk("R4 duty 256/128", hi, exp_high(256, 128));
    period(0, p);
    chk("R3 period step 256", p, 256);
    wr(0, mk(1, 1, 1024, 100));
    wait_idle(0, c);
    count_high(0, 64, hi);
    chk("R4 duty 1024/100", hi, exp_high(1024, 100));
    period(0, p);
    chk("R3 period step 1024", p, 64);
  endtask

  task automatic t_deferred();
    int hi, c;
    logic [31:0] d;
    wr(0, mk(1, 0, 256, 200));
    count_high(0, 64, hi);
    chk("R6 shadow write no effect", hi, exp_high(1024, 100));
    rd(0, d);
    chk("R6 shadow readback", d, mk(1, 0, 256, 200));
    wr(0, mk(1, 1, 256, 200));
    chk("R7 update bit held", {31'b0, busy}, 1);
    wait_idle(0, c);
    chk("R7 cleared within one cycle of output", {31'b0, (c <= 64)}, 1);
    rd(0, d);
    chk("R7 update bit cleared", d, mk(1, 0, 256, 200));
    count_high(0, 256, hi);
    chk("R7 new values active", hi, exp_high(256, 200));
  endtask

  task automatic t_busy();
    int hi, c;
    logic [31:0] d;
    wr(0, mk(1, 1, 256, 10));
    chk("R10 busy raised", {31'b0, busy}, 1);
    wr(0, mk(1, 0, 512, 20));
    wait_idle(0, c);
    rd(0, d);
    chk("R10 refused write discarded", d, mk(1, 0, 256, 10));
    count_high(0, 256, hi);
    chk("R10 output from accepted values", hi, exp_high(256, 10));
  endtask

  task automatic t_disable();
    int hi;
    wr(0, mk(0, 0, 256, 10));
    chk("R9 low right after disable", {31'b0, pwm[0]}, 0);
    count_high(0, 300, hi);
    chk("R9 stays low", hi, 0);
    wr(0, mk(1, 0, 256, 10));
    count_high(0, 300, hi);
    chk("R9 re-enable needs update", hi, 0);
  endtask

  task automatic t_channels();
    int hi, c;
    logic [31:0] d0, d1;
    rd(0, d0);
    configure(1, 256, 0);
    rd(0, d1);
    chk("R11 other readback unchanged", d1, d0);
    count_high(1, 256, hi);
    chk("R11 channel 1 runs", hi, 255);
    count_high(0, 256, hi);
    chk("R11 channel 0 untouched", hi, 0);
    wr(1, mk(1, 1, 256, 255));
    wait_idle(1, c);
    count_high(1, 512, hi);
    chk("R5 threshold 255 always low", hi, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_enable_needs_update();
    t_duty();
    t_deferred();
    t_busy();
    t_disable();
    t_channels();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule